// File: doc/BRIEF.md
# Two-Channel Priority Interrupt Arbiter

The arbiter looks at the pending, mask and route vectors of one to four banks of 32 interrupt lines. Each line also has a 6-bit priority value. Every line is a candidate for exactly one of two output channels: the normal channel or the fast channel. A line is a candidate only while it is pending and not masked. For each channel a combinational tree finds the winning line in a single cycle. A lower priority value wins. When two lines have the same priority, the higher global line number wins.

Each channel holds a new-agreement flag. A channel fires when three things are true in the same cycle: the flag is set, at least one candidate exists, and the global enable is high. On the next clock edge the winner code is latched, the request output rises and the flag clears. The channel then ignores all later candidate changes until software pulses that channel's re-arm strobe. The strobe drops the request, sets the flag again and evaluates the candidates in that same cycle. So if a candidate is already present, the channel fires again at once and its request stays high.

Register decoding, input capture and edge detection are handled elsewhere. This block sees only vectors and strobes.

Top module: `irq_arbiter`

## Requirements
- R1: Among the candidates of one channel, the line with the smaller priority value is latched; priority 0 is the most urgent.
- R2: When candidates share the lowest priority value, the line with the larger global index is latched.
- R3: A line is a candidate only while pend_i=1 and mask_i=0. It goes to the fast channel when route_i=1 and to the normal channel when route_i=0.
- R4: The latched code is the global line number, which is 32 times the bank index plus the bit position within the bank. Line i uses pend_i[i], mask_i[i], route_i[i] and prio_i[6*i+:6].
- R5: A channel fires when its agreement flag is set, it has a candidate and glob_en_i=1. On the next clock its request output goes to 1 and its code output takes the winner. Both then hold while candidates change, until a re-arm.
- R6: A one-cycle re-arm pulse (rearm_i[0] for normal, rearm_i[1] for fast) is evaluated in the same cycle. If the channel has a candidate and glob_en_i=1, the request stays 1 and the new winner is latched on the next clock. Otherwise the request is 0 on the next clock and the code holds.
- R7: After reset both request outputs are 0, both codes are 0 and both channels are armed.
- R8: While glob_en_i=0 neither channel fires. An armed channel fires on the first clock at which glob_en_i=1 and a candidate exists.
- R9: The two channels are independent. A re-arm or a firing on one channel leaves the other channel's request and code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pend_i | input | 32*NUM_BANKS | Pending bit per line |
| mask_i | input | 32*NUM_BANKS | 1 = line masked |
| route_i | input | 32*NUM_BANKS | 1 = fast channel, 0 = normal channel |
| prio_i | input | 32*NUM_BANKS*PRIO_W | Priority per line, line i at [i*PRIO_W +: PRIO_W] |
| glob_en_i | input | 1 | Global enable for both channels |
| rearm_i | input | 2 | Re-arm strobes, bit 0 normal, bit 1 fast |
| nrm_req_o | output | 1 | Normal channel request |
| nrm_code_o | output | $clog2(32*NUM_BANKS) | Latched normal winner |
| fst_req_o | output | 1 | Fast channel request |
| fst_code_o | output | $clog2(32*NUM_BANKS) | Latched fast winner |

## Verification
The assertions check several rules on every cycle:
- A request rises only after a cycle with the global enable high.
- A newly latched code names a line that was a valid candidate for that channel one cycle earlier.
- A code changes only while the request is high.
- A request without a re-arm stays high.
- A re-arm while the global enable is low always drops the request.

Other behaviour can be shown only by the bench scenarios, which compare the outputs with a behavioural model:
- that the latched line is the true minimum-priority winner, with ties going to the higher index;
- that a re-arm fires again at once when a candidate is already waiting;
- that one channel is isolated from the other.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned LINES_PER_BANK = 32;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic {CH_NRM = 1'b0, CH_FST = 1'b1} ch_e;
endpackage

// File: rtl/arb_prio_tree.sv
module arb_prio_tree #(
  parameter int unsigned N      = 64,
  parameter int unsigned PRIO_W = 6,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [N-1:0]        cand_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  output logic                valid_o,
  output logic [IDX_W-1:0]    idx_o
);
  localparam int unsigned LVL    = $clog2(N);
  localparam int unsigned LEAVES = 1 << LVL;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N) begin : g_real
      assign nv[LEAVES-1+j] = cand_i[j];
      assign np[LEAVES-1+j] = prio_i[j*PRIO_W +: PRIO_W];
      assign ni[LEAVES-1+j] = IDX_W'(j);
    end else begin : g_pad
      assign nv[LEAVES-1+j] = 1'b0;
      assign np[LEAVES-1+j] = '1;
      assign ni[LEAVES-1+j] = '0;
    end
  end

  // right child covers higher indices: it wins ties
  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    logic take_r;
    assign take_r = nv[2*k+2] && (!nv[2*k+1] || (np[2*k+2] <= np[2*k+1]));
    assign nv[k]  = nv[2*k+1] | nv[2*k+2];
    assign np[k]  = take_r ? np[2*k+2] : np[2*k+1];
    assign ni[k]  = take_r ? ni[2*k+2] : ni[2*k+1];
  end

  assign valid_o = nv[0];
  assign idx_o   = nv[0] ? ni[0] : '0;
endmodule

// File: rtl/arb_channel.sv
module arb_channel #(
  parameter int unsigned IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             glob_en_i,
  input  logic             rearm_i,
  output logic             req_o,
  output logic [IDX_W-1:0] code_o
);
  logic agree_q, agree_eff, fire;

  assign agree_eff = agree_q | rearm_i;
  assign fire      = agree_eff & win_valid_i & glob_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agree_q <= 1'b1;
      req_o   <= 1'b0;
      code_o  <= '0;
    end else begin
      agree_q <= agree_eff & ~fire;
      if (fire) begin
        req_o  <= 1'b1;
        code_o <= win_idx_i;
      end else if (rearm_i) begin
        req_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned PRIO_W    = 6,
  localparam int unsigned N        = LINES_PER_BANK * NUM_BANKS,
  localparam int unsigned CODE_W   = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N-1:0]        pend_i,
  input  logic [N-1:0]        mask_i,
  input  logic [N-1:0]        route_i,
  input  logic [N*PRIO_W-1:0] prio_i,
  input  logic                glob_en_i,
  input  logic [1:0]          rearm_i,
  output logic                nrm_req_o,
  output logic [CODE_W-1:0]   nrm_code_o,
  output logic                fst_req_o,
  output logic [CODE_W-1:0]   fst_code_o
);
  logic [N-1:0]      live;
  logic              req  [NUM_CH];
  logic [CODE_W-1:0] code [NUM_CH];

  assign live = pend_i & ~mask_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [N-1:0]      cand;
    logic              wv;
    logic [CODE_W-1:0] wi;

    if (c == int'(CH_FST)) begin : g_fst
      assign cand = live & route_i;
    end else begin : g_nrm
      assign cand = live & ~route_i;
    end

    arb_prio_tree #(.N(N), .PRIO_W(PRIO_W), .IDX_W(CODE_W)) u_tree (
      .cand_i (cand),
      .prio_i (prio_i),
      .valid_o(wv),
      .idx_o  (wi)
    );

    arb_channel #(.IDX_W(CODE_W)) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .win_valid_i(wv),
      .win_idx_i  (wi),
      .glob_en_i  (glob_en_i),
      .rearm_i    (rearm_i[c]),
      .req_o      (req[c]),
      .code_o     (code[c])
    );
  end

  assign nrm_req_o  = req[int'(CH_NRM)];
  assign nrm_code_o = code[int'(CH_NRM)];
  assign fst_req_o  = req[int'(CH_FST)];
  assign fst_code_o = code[int'(CH_FST)];
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int unsigned N      = 64,
  parameter int unsigned CODE_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      pend_i,
  input logic [N-1:0]      mask_i,
  input logic [N-1:0]      route_i,
  input logic              glob_en_i,
  input logic [1:0]        rearm_i,
  input logic              nrm_req_o,
  input logic [CODE_W-1:0] nrm_code_o,
  input logic              fst_req_o,
  input logic [CODE_W-1:0] fst_code_o
);
  logic [N-1:0] ncand_q, fcand_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ncand_q <= '0;
      fcand_q <= '0;
    end else begin
      ncand_q <= pend_i & ~mask_i & ~route_i;
      fcand_q <= pend_i & ~mask_i & route_i;
    end
  end

  // R8
  nrm_rise_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nrm_req_o) |-> $past(glob_en_i));
  // R8
  fst_rise_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fst_req_o) |-> $past(glob_en_i));
  // R3
  nrm_code_is_cand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nrm_req_o) |-> ncand_q[nrm_code_o]);
  // R3
  fst_code_is_cand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fst_req_o) |-> fcand_q[fst_code_o]);
  // R5
  nrm_code_moves_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(nrm_code_o) |-> nrm_req_o);
  // R5
  fst_code_moves_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fst_code_o) |-> fst_req_o);
  // R5
  nrm_req_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nrm_req_o && !rearm_i[0] |=> nrm_req_o);
  // R5
  fst_req_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fst_req_o && !rearm_i[1] |=> fst_req_o);
  // R6
  nrm_rearm_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i[0] && !glob_en_i |=> !nrm_req_o);
  // R6
  fst_rearm_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i[1] && !glob_en_i |=> !fst_req_o);
endmodule

bind irq_arbiter irq_arbiter_chk #(.N(N), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_i), .mask_i(mask_i),
  .route_i(route_i), .glob_en_i(glob_en_i), .rearm_i(rearm_i),
  .nrm_req_o(nrm_req_o), .nrm_code_o(nrm_code_o),
  .fst_req_o(fst_req_o), .fst_code_o(fst_code_o)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
  localparam int NB = 2;
  localparam int PW = 6;
  localparam int N  = 32 * NB;
  localparam int CW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pend = '0, mask = '0, route = '0;
  logic [N*PW-1:0] prio_flat;
  logic          glob_en = 1'b1;
  logic [1:0]    rearm = 2'b00;
  logic          nrm_req, fst_req;
  logic [CW-1:0] nrm_code, fst_code;

  int prio [N];
  int errors = 0, checks = 0;
  bit done = 0;

  // model state
  int m_req [2], m_code [2], m_agree [2];

  always #2.5 clk = ~clk;

  always_comb
    for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = PW'(prio[i]);

  irq_arbiter #(.NUM_BANKS(NB), .PRIO_W(PW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mask_i(mask), .route_i(route),
    .prio_i(prio_flat), .glob_en_i(glob_en), .rearm_i(rearm),
    .nrm_req_o(nrm_req), .nrm_code_o(nrm_code),
    .fst_req_o(fst_req), .fst_code_o(fst_code));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin m_req[c] = 0; m_code[c] = 0; m_agree[c] = 1; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int best, bp, eff;
        best = -1; bp = 0;
        for (int i = 0; i < N; i++)
          if (pend[i] && !mask[i] && (int'(route[i]) == c) && (best < 0 || prio[i] <= bp)) begin
            best = i; bp = prio[i];
          end
        eff = m_agree[c] | int'(rearm[c]);
        if (eff != 0 && best >= 0 && glob_en) begin
          m_req[c] = 1; m_code[c] = best; m_agree[c] = 0;
        end else begin
          m_agree[c] = eff;
          if (rearm[c]) m_req[c] = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R5 model nrm_req", int'(nrm_req), m_req[0]);
    chk("R1 model nrm_code", int'(nrm_code), m_code[0]);
    chk("R6 model fst_req", int'(fst_req), m_req[1]);
    chk("R2 model fst_code", int'(fst_code), m_code[1]);
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) prio[i] = 63;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 nrm_req", int'(nrm_req), 0);  chk("R7 nrm_code", int'(nrm_code), 0);
    chk("R7 fst_req", int'(fst_req), 0);  chk("R7 fst_code", int'(fst_code), 0);

    prio[5] = 3; prio[40] = 10; pend[5] = 1; pend[40] = 1;
    @(negedge clk);
    chk("R1 nrm_req", int'(nrm_req), 1);  chk("R1 nrm_code", int'(nrm_code), 5);

    prio[60] = 0; pend[60] = 1;
    @(negedge clk);
    chk("R5 hold code", int'(nrm_code), 5); chk("R5 hold req", int'(nrm_req), 1);

    rearm = 2'b01;
    @(negedge clk); rearm = 2'b00;
    chk("R6 refire req", int'(nrm_req), 1); chk("R6 refire code", int'(nrm_code), 60);

    pend = '0; prio[7] = 2; prio[39] = 2; pend[7] = 1; pend[39] = 1; rearm = 2'b01;
    @(negedge clk); rearm = 2'b00;
    chk("R2 tie code", int'(nrm_code), 39);
    chk("R4 bank1 bit7", int'(nrm_code), 32 + 7);

    route[39] = 1;
    @(negedge clk);
    chk("R3 fst_req", int'(fst_req), 1); chk("R3 fst_code", int'(fst_code), 39);
    chk("R5 nrm blocked", int'(nrm_code), 39);

    rearm = 2'b01;
    @(negedge clk); rearm = 2'b00;
    chk("R3 route excl", int'(nrm_code), 7);

    mask[7] = 1; rearm = 2'b01;
    @(negedge clk); rearm = 2'b00;
    chk("R6 drop req", int'(nrm_req), 0); chk("R6 code held", int'(nrm_code), 7);
    chk("R9 fst req", int'(fst_req), 1);  chk("R9 fst code", int'(fst_code), 39);

    glob_en = 0; mask[7] = 0;
    @(negedge clk);
    chk("R8 blocked", int'(nrm_req), 0);
    @(negedge clk);
    chk("R8 still blocked", int'(nrm_req), 0);
    glob_en = 1;
    @(negedge clk);
    chk("R8 fires req", int'(nrm_req), 1); chk("R8 fires code", int'(nrm_code), 7);

    pend[39] = 0; rearm = 2'b10;
    @(negedge clk); rearm = 2'b00;
    chk("R9 fst dropped", int'(fst_req), 0);
    chk("R9 nrm req", int'(nrm_req), 1); chk("R9 nrm code", int'(nrm_code), 7);

    for (int cyc = 0; cyc < 3000; cyc++) begin
      pend  = {$urandom, $urandom} & {$urandom, $urandom};
      mask  = {$urandom, $urandom} & {$urandom, $urandom};
      route = {$urandom, $urandom};
      rearm = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
      glob_en = ($urandom % 8) != 0;
      if (($urandom % 16) == 0)
        for (int i = 0; i < N; i++) prio[i] = int'($urandom % 4);
      @(negedge clk);
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule